// File: doc/BRIEF.md
# Return-from-Exception Status Unwinder

This block carries out the status-register half of a return-from-exception operation. When the return strobe is high for a cycle, it pops one level of the flag stack in the status word. Bits 31:30 stay in place. The low 28 bits move right by 10 positions, and bits 29:28 are discarded.

If the popped word says the processor goes back to user mode, the block also swaps stacks. The live stack pointer is kept as the kernel stack pointer, and the saved user stack pointer becomes the live one. The block then sets the store-pending flag, unless the popped word has the restart flag set.

A second strobe marks a conditional store. Such a store fails when the store-pending flag is set in the status word presented in that cycle, and the block reports this on its failure output.

In a cycle without the return strobe, the block passes the status word and stack pointer through its output registers unchanged and keeps the kernel stack pointer. All outputs are registered. A result appears one clock after the inputs that produced it.

Top module: `rfe_unwinder`

## Requirements
- R1: While `rst` is high at a rising edge, `stat_o`, `sp_o`, `ksp_o` and `store_fail_o` become zero.
- R2: One cycle after a cycle with `rfe_i` high, the stored status word is built as follows:
  - bits 31:30 equal the old bits 31:30;
  - bits 29:18 are zero;
  - bits 17:0 equal the old bits 27:10, apart from the change to bit 7 given in R5.
- R3: One cycle after `rfe_i` high with old status bit 16 set (the popped user flag, bit 6 after the pop), `ksp_o` equals the old `sp_i` and `sp_o` equals the old `usp_i`.
- R4: One cycle after `rfe_i` high with old status bit 16 clear, `sp_o` equals the old `sp_i` and `ksp_o` keeps its previous value.
- R5: After a pop, bit 7 (store-pending) of `stat_o` is forced to 1 when popped bit 8 (restart, old bit 18) is 0. When popped bit 8 is 1, bit 7 is the popped value (old bit 17).
- R6: One cycle after a cycle with `rfe_i` low, `stat_o` equals the old `stat_i` and `sp_o` equals the old `sp_i`, and `ksp_o` is unchanged.
- R7: One cycle after `cstore_i` is high, `store_fail_o` equals bit 7 of the `stat_i` value from that cycle. It is 0 whenever `cstore_i` was low. This holds whether or not `rfe_i` was high in the same cycle.
- R8: The status word and the stack pointers update together, on the same clock edge, one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rfe_i | input | 1 | Return-from-exception strobe |
| cstore_i | input | 1 | Conditional-store strobe |
| stat_i | input | 32 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| usp_i | input | 32 | Saved user stack pointer |
| stat_o | output | 32 | New status word |
| sp_o | output | 32 | New stack pointer |
| ksp_o | output | 32 | Saved kernel stack pointer |
| store_fail_o | output | 1 | Conditional-store failure |

## Verification
The hardest case to reach is a return that lands in user mode while the popped restart flag is set. In that case the store-pending bit must come from the popped word and not be forced. It needs old bits 16 and 18 set together, and old bit 17 chosen separately.

A second hard case is a conditional store in the same cycle as a return. The failure must follow the pre-pop flag, not the new one.

Directed vectors aim at both cases with both values of bit 17. Random status words with random strobes then cover the mixed orderings. Some of those draws give a run of returns with no stack swap, which shows that the kernel pointer is held.

// File: rtl/rfe_unwind_pkg.sv
package rfe_unwind_pkg;

    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // registered state of the unwinder
    typedef struct packed {
        word_t stat;
        word_t sp;
        word_t ksp;
        logic  fail;
    } unwind_state_t;

    // pointer choice made by the stack selector
    typedef struct packed {
        word_t sp_next;
        logic  ksp_load;
    } sp_choice_t;

    function automatic word_t keep_mask(input int unsigned keep_hi);
        word_t m;
        m = '1;
        return ~(m >> keep_hi);
    endfunction

    function automatic word_t field_mask(input int unsigned keep_hi, input int unsigned gap);
        word_t m;
        m = '1;
        return m >> (keep_hi + gap);
    endfunction

endpackage

// File: rtl/rfe_flag_pop.sv
module rfe_flag_pop
    import rfe_unwind_pkg::*;
#(
    parameter int unsigned KEEP_HI = 2,
    parameter int unsigned GAP     = 2,
    parameter int unsigned SHIFT   = 10,
    parameter int unsigned U_BIT   = 6,
    parameter int unsigned P_BIT   = 7,
    parameter int unsigned R_BIT   = 8
) (
    input  word_t stat_in,
    output word_t stat_pop,
    output logic  user_flag
);
    localparam word_t HI_MASK  = keep_mask(KEEP_HI);
    localparam word_t LOW_MASK = field_mask(KEEP_HI, GAP);

    word_t shifted;

    always_comb begin
        shifted  = (stat_in & HI_MASK) | ((stat_in & LOW_MASK) >> SHIFT);
        stat_pop = shifted;
        if (!shifted[R_BIT]) begin
            stat_pop[P_BIT] = 1'b1;
        end
        user_flag = shifted[U_BIT];
    end

    // R5
    always_comb begin
        p_forced_chk: assert (shifted[R_BIT] || stat_pop[P_BIT]);
    end
endmodule

// File: rtl/rfe_sp_select.sv
module rfe_sp_select
    import rfe_unwind_pkg::*;
(
    input  logic       do_rfe,
    input  logic       to_user,
    input  word_t      sp_cur,
    input  word_t      sp_user,
    output sp_choice_t choice
);
    always_comb begin
        choice.sp_next  = sp_cur;
        choice.ksp_load = 1'b0;
        if (do_rfe && to_user) begin
            choice.sp_next  = sp_user;
            choice.ksp_load = 1'b1;
        end
    end

    // R4
    always_comb begin
        no_swap_chk: assert (choice.ksp_load || choice.sp_next == sp_cur);
    end
endmodule

// File: rtl/rfe_store_guard.sv
module rfe_store_guard
    import rfe_unwind_pkg::*;
#(
    parameter int unsigned P_BIT = 7
) (
    input  logic  cstore,
    input  word_t stat_cur,
    output logic  fail
);
    assign fail = cstore & stat_cur[P_BIT];
endmodule

// File: rtl/rfe_unwinder.sv
module rfe_unwinder
    import rfe_unwind_pkg::*;
#(
    parameter int unsigned KEEP_HI = 2,
    parameter int unsigned GAP     = 2,
    parameter int unsigned SHIFT   = 10,
    parameter int unsigned U_BIT   = 6,
    parameter int unsigned P_BIT   = 7,
    parameter int unsigned R_BIT   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rfe_i,
    input  logic              cstore_i,
    input  logic [WORD_W-1:0] stat_i,
    input  logic [WORD_W-1:0] sp_i,
    input  logic [WORD_W-1:0] usp_i,
    output logic [WORD_W-1:0] stat_o,
    output logic [WORD_W-1:0] sp_o,
    output logic [WORD_W-1:0] ksp_o,
    output logic              store_fail_o
);
    localparam int unsigned OLD_U = U_BIT + SHIFT;
    localparam int unsigned OLD_R = R_BIT + SHIFT;

    word_t         stat_pop;
    logic          user_flag;
    sp_choice_t    choice;
    logic          fail_now;
    unwind_state_t st_q;
    unwind_state_t st_d;

    rfe_flag_pop #(
        .KEEP_HI(KEEP_HI), .GAP(GAP), .SHIFT(SHIFT),
        .U_BIT(U_BIT), .P_BIT(P_BIT), .R_BIT(R_BIT)
    ) pop_i (
        .stat_in  (stat_i),
        .stat_pop (stat_pop),
        .user_flag(user_flag)
    );

    rfe_sp_select sel_i (
        .do_rfe (rfe_i),
        .to_user(user_flag),
        .sp_cur (sp_i),
        .sp_user(usp_i),
        .choice (choice)
    );

    rfe_store_guard #(.P_BIT(P_BIT)) guard_i (
        .cstore  (cstore_i),
        .stat_cur(stat_i),
        .fail    (fail_now)
    );

    always_comb begin
        st_d.stat = rfe_i ? stat_pop : stat_i;
        st_d.sp   = choice.sp_next;
        st_d.ksp  = choice.ksp_load ? sp_i : st_q.ksp;
        st_d.fail = fail_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o       = st_q.stat;
    assign sp_o         = st_q.sp;
    assign ksp_o        = st_q.ksp;
    assign store_fail_o = st_q.fail;

    // R2
    hi_keep_chk: assert property (@(posedge clk) disable iff (rst)
        rfe_i |=> stat_o[WORD_W-1 -: KEEP_HI] == $past(stat_i[WORD_W-1 -: KEEP_HI]));

    // R3
    user_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (rfe_i && stat_i[OLD_U]) |=> (sp_o == $past(usp_i) && ksp_o == $past(sp_i)));

    // R4
    kernel_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (rfe_i && !stat_i[OLD_U]) |=> (sp_o == $past(sp_i) && $stable(ksp_o)));

    // R5
    p_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rfe_i && !stat_i[OLD_R]) |=> stat_o[P_BIT]);

    // R6
    pass_chk: assert property (@(posedge clk) disable iff (rst)
        !rfe_i |=> (stat_o == $past(stat_i) && sp_o == $past(sp_i) && $stable(ksp_o)));

    // R7
    fail_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> store_fail_o == ($past(cstore_i) && $past(stat_i[P_BIT])));
endmodule

// File: tb/rfe_unwinder_tb_top.sv
module rfe_unwinder_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        rfe_i, cstore_i;
    logic [31:0] stat_i, sp_i, usp_i;
    logic [31:0] stat_o, sp_o, ksp_o;
    logic        store_fail_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] stat;
        logic [31:0] sp;
        logic [31:0] ksp;
        logic        fail;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] m_ksp;
    bit          done = 0;

    always #4 clk = ~clk;

    rfe_unwinder dut_i (
        .clk(clk), .rst(rst), .rfe_i(rfe_i), .cstore_i(cstore_i),
        .stat_i(stat_i), .sp_i(sp_i), .usp_i(usp_i),
        .stat_o(stat_o), .sp_o(sp_o), .ksp_o(ksp_o), .store_fail_o(store_fail_o)
    );

    function automatic logic [31:0] model_pop(input logic [31:0] s);
        logic [31:0] r;
        r = {s[31:30], 12'b0, s[27:10]};
        if (!r[8]) r[7] = 1'b1;
        return r;
    endfunction

    task automatic drive(input logic r, input logic rf, input logic cs,
                         input logic [31:0] st, input logic [31:0] sp,
                         input logic [31:0] usp, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; rfe_i = rf; cstore_i = cs; stat_i = st; sp_i = sp; usp_i = usp;
        if (r) begin
            e.stat = 0; e.sp = 0; m_ksp = 0; e.fail = 0;
        end else begin
            e.fail = cs & st[7];
            if (rf) begin
                e.stat = model_pop(st);
                if (e.stat[6]) begin
                    m_ksp = sp; e.sp = usp;
                end else begin
                    e.sp = sp;
                end
            end else begin
                e.stat = st; e.sp = sp;
            end
        end
        e.ksp = m_ksp;
        e.tag = tag;
        @(posedge clk);
        #1 sb_q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp(e.tag, "stat", stat_o, e.stat);
            cmp(e.tag, "sp", sp_o, e.sp);
            cmp(e.tag, "ksp", ksp_o, e.ksp);
            cmp(e.tag, "fail", {31'b0, store_fail_o}, {31'b0, e.fail});
        end
    end

    initial begin
        rst = 1; rfe_i = 0; cstore_i = 0; stat_i = 0; sp_i = 0; usp_i = 0; m_ksp = 0;
        drive(1, 1, 1, 32'hFFFF_FFFF, 32'h1111, 32'h2222, "R1 reset");
        drive(0, 0, 0, 32'h1234_5678, 32'hA000_0000, 32'hB0, "R6 pass");
        // R3: old bit16 set -> user; old bit18 clear -> R5 forces P
        drive(0, 1, 0, 32'h4001_0000, 32'h0000_1000, 32'h0000_2000, "R3 swap");
        drive(0, 1, 0, 32'h8000_0400, 32'h0000_3000, 32'h0000_4000, "R4 noswap");
        drive(0, 0, 0, 32'h0000_0000, 32'h0000_5000, 32'h0000_6000, "R6 ksp hold");
        // R5: user plus restart set, old bit17 both ways
        drive(0, 1, 0, 32'h0005_0000, 32'h0000_7000, 32'h0000_8000, "R5 Rset Pclr");
        drive(0, 1, 0, 32'h0007_0000, 32'h0000_9000, 32'h0000_A000, "R5 Rset Pset");
        drive(0, 1, 0, 32'hFFFF_FFFF, 32'hCAFE_0000, 32'hBEEF_0000, "R2 ones");
        drive(0, 1, 0, 32'h0000_0000, 32'h0000_0001, 32'h0000_0002, "R2 zeros");
        drive(0, 0, 1, 32'h0000_0080, 32'h10, 32'h20, "R7 fail");
        drive(0, 0, 1, 32'h0000_0000, 32'h10, 32'h20, "R7 ok");
        drive(0, 1, 1, 32'h0000_0080, 32'h30, 32'h40, "R7 with rfe");
        drive(0, 1, 1, 32'h0000_0000, 32'h30, 32'h40, "R7 rfe noP");
        drive(0, 1, 0, 32'h3001_0000, 32'h50, 32'h60, "R8 back2back a");
        drive(0, 1, 0, 32'h0001_0000, 32'h70, 32'h80, "R8 back2back b");
        for (int i = 0; i < 60; i++) begin
            drive(0, 1'($urandom), 1'($urandom), $urandom, $urandom, $urandom, "R2 R3 R4 R5 R7 rnd");
        end
        drive(1, 0, 0, 32'h0, 32'h0, 32'h0, "R1 reset again");
        @(negedge clk);
        @(negedge clk);
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule